// File: doc/BRIEF.md
# CAN Fault Confinement and Error Interrupt Unit

This unit keeps the transmit and receive error counters of a CAN controller and derives the fault-confinement states from them: transmit warning, receive warning, error-passive and bus-off. A protocol engine feeds it single-cycle event pulses: bit, form and stuff errors (with a flag saying whether the node was transmitting), successful transmit and receive, and a lost-message pulse. From these the unit keeps a write-one-to-clear global status register, a mask register and a sticky error-cause register. Its single error interrupt line is the OR of the masked status bits.

Software reaches the unit through a simple register port. A write takes effect at the clock edge where `reg_wr` is sampled high. A read returns data one cycle after `reg_rd` is sampled. The same port carries the configuration-mode and sleep-mode request/acknowledge handshakes and a self-clearing soft reset. The register addresses are: 0 control, 1 mode status, 2 counters, 3 global status, 4 global mask, 5 error cause, 6 sleep.

Event counting is frozen in three cases: while configuration mode is acknowledged, while sleep is acknowledged, and while the unit is bus-off. The lost-message pulse is never frozen.

Top module: `can_fault_supervisor`

## Requirements
- R1: Address 2 reads the transmit counter in bits 15:8 and the receive counter in bits 7:0. A counted error raises the transmit counter by 8 when `ev_while_tx` is 1. Otherwise it raises the receive counter by 1, and the receive counter saturates at 255. A success pulse lowers its counter by 1, with a floor of 0.
- R2: In the global status register (address 3), bit 0 is transmit warning and bit 1 is receive warning; each is set on the rising edge of its counter reaching 96. Bit 2 is error-passive and is set on the rising edge of either counter reaching 128. A bit sets one cycle after the counter update.
- R3: An error while transmitting that would take the transmit counter past 255 enters bus-off. Both counters become 0, and status bit 3 is set one cycle later. Further events are then ignored until a soft reset.
- R4: Writing ones to the global status register clears those bits, so writing 0x7FF clears all of them. A bit whose set condition arrives in the same cycle as its clear stays set.
- R5: A lost-message pulse sets global status bit 7 at the next edge.
- R6: `err_irq` equals the OR of (global status AND global mask, address 4), taken from the register values one cycle earlier.
- R7: The error-cause register (address 5) is sticky: bit 6 records a bit error, bit 7 a form error and bit 3 a stuff error. Writing ones clears those bits.
- R8: Control bit 7 (address 0) requests configuration mode. The acknowledge appears in bit 7 of address 1 one cycle later and clears one cycle after the request is withdrawn. While the acknowledge is set, error and success events change nothing.
- R9: Control bit 5 requests sleep. The acknowledge appears in bit 3 of address 6 one cycle later. Writing 0 to address 6 clears both the request and the acknowledge. While asleep, events change nothing.
- R10: Writing control bit 0 is a soft reset. It clears the counters, the global status, the error cause and bus-off, clears sleep and sets the configuration request. The acknowledge follows within 2 cycles.
- R11: When an error and a success pulse for the same counter arrive together, only the error is counted.
- R12: After reset the control register reads 0x0080, the mode status reads 0x0080, the counters read 0 and `err_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bit_err | input | 1 | Bit error pulse |
| ev_form_err | input | 1 | Form error pulse |
| ev_stuff_err | input | 1 | Stuff error pulse |
| ev_while_tx | input | 1 | Qualifies an error pulse as occurring while transmitting |
| ev_tx_ok | input | 1 | Successful transmission pulse |
| ev_rx_ok | input | 1 | Successful reception pulse |
| ev_msg_lost | input | 1 | Received message lost pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one cycle after the read strobe |
| err_irq | output | 1 | Error interrupt |

## Verification
Two functions can land in the same cycle: a software write-one-to-clear of a status bit, and the rising edge of that bit's own condition. The bench provokes this by lowering the receive counter to 95 and raising it back to 96. It then issues the clear of bit 1 on exactly the edge where the warning edge is registered, and requires the bit to survive. A second collision puts an error and a success pulse on the same counter in one cycle; the error must be counted and the success dropped. A behavioural model checks `err_irq` and every read result on every clock.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_MODE  = 3'd1;
  localparam logic [2:0] A_CNT   = 3'd2;
  localparam logic [2:0] A_GSTAT = 3'd3;
  localparam logic [2:0] A_GMASK = 3'd4;
  localparam logic [2:0] A_CAUSE = 3'd5;
  localparam logic [2:0] A_SLEEP = 3'd6;

  // global status bit positions (software decodes these)
  localparam int GS_TXWARN  = 0;
  localparam int GS_RXWARN  = 1;
  localparam int GS_PASSIVE = 2;
  localparam int GS_BUSOFF  = 3;
  localparam int GS_LOST    = 7;

  // control / mode / sleep bit positions
  localparam int CT_SRST  = 0;
  localparam int CT_SLEEP = 5;
  localparam int CT_CFG   = 7;
  localparam int MD_CFGACK = 7;
  localparam int SL_ACK    = 3;

  // error cause bit positions
  localparam int EC_STUFF = 3;
  localparam int EC_BIT   = 6;
  localparam int EC_FORM  = 7;

  typedef struct packed {
    logic bus_off;
    logic passive;
    logic rx_warn;
    logic tx_warn;
  } err_cond_t;
endpackage

// File: rtl/can_fault_counters.sv
module can_fault_counters
  import can_fault_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hold,
  input  logic             err_any,
  input  logic             on_tx,
  input  logic             tx_ok,
  input  logic             rx_ok,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic             bus_off,
  output err_cond_t        cond
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
  localparam int unsigned SUM_W   = CNT_W + 1;

  logic [SUM_W-1:0] tec_sum, rec_sum;
  logic             tec_ovf;
  logic [CNT_W-1:0] rec_inc, tec_dec, rec_dec;

  assign tec_sum = {1'b0, tec} + SUM_W'(TX_STEP);
  assign rec_sum = {1'b0, rec} + SUM_W'(RX_STEP);
  assign tec_ovf = tec_sum > SUM_W'(CNT_MAX);
  assign rec_inc = (rec_sum > SUM_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : rec_sum[CNT_W-1:0];
  assign tec_dec = (tx_ok && tec != '0) ? tec - 1'b1 : tec;
  assign rec_dec = (rx_ok && rec != '0) ? rec - 1'b1 : rec;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tec     <= '0;
      rec     <= '0;
      bus_off <= 1'b0;
    end else if (!hold) begin
      if (err_any) begin
        if (on_tx) begin
          if (tec_ovf) begin
            bus_off <= 1'b1;
            tec     <= '0;
            rec     <= '0;
          end else begin
            tec <= tec_sum[CNT_W-1:0];
          end
        end else begin
          rec <= rec_inc;
        end
      end else begin
        tec <= tec_dec;
        rec <= rec_dec;
      end
    end
  end

  assign cond.tx_warn = tec >= CNT_W'(WARN_LVL);
  assign cond.rx_warn = rec >= CNT_W'(WARN_LVL);
  assign cond.passive = (tec >= CNT_W'(PASSIVE_LVL)) || (rec >= CNT_W'(PASSIVE_LVL));
  assign cond.bus_off = bus_off;
endmodule

// File: rtl/can_fault_irq.sv
module can_fault_irq
  import can_fault_pkg::*;
#(
  parameter int GS_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  err_cond_t       cond,
  input  logic            lost,
  input  logic            w1c_en,
  input  logic [GS_W-1:0] w1c_bits,
  input  logic            mask_we,
  input  logic [GS_W-1:0] mask_d,
  output logic [GS_W-1:0] gstat,
  output logic [GS_W-1:0] gmask,
  output logic            irq
);
  localparam int N_COND = $bits(err_cond_t);
  localparam int COND_POS [N_COND] = '{GS_BUSOFF, GS_PASSIVE, GS_RXWARN, GS_TXWARN};

  err_cond_t        prev;
  logic [N_COND-1:0] rise;
  logic [GS_W-1:0]  set_v;
  logic [GS_W-1:0]  clr_v;

  assign rise = cond & ~prev;

  always_comb begin
    set_v = '0;
    for (int i = 0; i < N_COND; i++) begin
      set_v[COND_POS[N_COND-1-i]] = rise[i];
    end
    set_v[GS_LOST] = lost;
  end

  assign clr_v = w1c_en ? w1c_bits : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev  <= '0;
      gstat <= '0;
      irq   <= 1'b0;
    end else begin
      prev  <= cond;
      gstat <= (gstat & ~clr_v) | set_v;
      irq   <= |(gstat & gmask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gmask <= '0;
    else if (mask_we) gmask <= mask_d;
  end
endmodule

// File: rtl/can_fault_mode.sv
module can_fault_mode
  import can_fault_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic          sleep_we,
  input  logic [DW-1:0] wdata,
  output logic          cfg_req,
  output logic          cfg_ack,
  output logic          slp_req,
  output logic          slp_ack,
  output logic          srst
);
  logic leave_sleep;

  assign srst        = ctrl_we && wdata[CT_SRST];
  assign leave_sleep = sleep_we && (wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_req <= 1'b1;
      cfg_ack <= 1'b1;
      slp_req <= 1'b0;
      slp_ack <= 1'b0;
    end else begin
      cfg_ack <= cfg_req;
      if (srst) begin
        cfg_req <= 1'b1;
        slp_req <= 1'b0;
        slp_ack <= 1'b0;
      end else begin
        if (ctrl_we) begin
          cfg_req <= wdata[CT_CFG];
          slp_req <= wdata[CT_SLEEP];
        end
        if (leave_sleep) begin
          slp_req <= 1'b0;
          slp_ack <= 1'b0;
        end else begin
          slp_ack <= slp_req;
        end
      end
    end
  end
endmodule

// File: rtl/can_fault_supervisor.sv
module can_fault_supervisor
  import can_fault_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int GS_W        = 11,
  parameter int DW          = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_bit_err,
  input  logic          ev_form_err,
  input  logic          ev_stuff_err,
  input  logic          ev_while_tx,
  input  logic          ev_tx_ok,
  input  logic          ev_rx_ok,
  input  logic          ev_msg_lost,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          err_irq
);
  logic             ctrl_we, sleep_we, gstat_we, gmask_we, cause_we;
  logic             cfg_req, cfg_ack, slp_req, slp_ack, srst;
  logic             hold, err_any, bus_off;
  logic [CNT_W-1:0] tec, rec;
  err_cond_t        cond;
  logic [GS_W-1:0]  gstat, gmask;
  logic [2:0]       cause;   // {form, bit, stuff}
  logic [2:0]       cause_set, cause_clr;

  assign ctrl_we  = reg_wr && reg_addr == A_CTRL;
  assign sleep_we = reg_wr && reg_addr == A_SLEEP;
  assign gstat_we = reg_wr && reg_addr == A_GSTAT;
  assign gmask_we = reg_wr && reg_addr == A_GMASK;
  assign cause_we = reg_wr && reg_addr == A_CAUSE;

  assign err_any = ev_bit_err || ev_form_err || ev_stuff_err;

  can_fault_mode #(.DW(DW)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .ctrl_we  (ctrl_we),
    .sleep_we (sleep_we),
    .wdata    (reg_wdata),
    .cfg_req  (cfg_req),
    .cfg_ack  (cfg_ack),
    .slp_req  (slp_req),
    .slp_ack  (slp_ack),
    .srst     (srst)
  );

  assign hold = cfg_ack || slp_ack || bus_off;

  can_fault_counters #(
    .CNT_W       (CNT_W),
    .WARN_LVL    (WARN_LVL),
    .PASSIVE_LVL (PASSIVE_LVL),
    .TX_STEP     (TX_STEP),
    .RX_STEP     (RX_STEP)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (srst),
    .hold    (hold),
    .err_any (err_any),
    .on_tx   (ev_while_tx),
    .tx_ok   (ev_tx_ok),
    .rx_ok   (ev_rx_ok),
    .tec     (tec),
    .rec     (rec),
    .bus_off (bus_off),
    .cond    (cond)
  );

  can_fault_irq #(.GS_W(GS_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .clr      (srst),
    .cond     (cond),
    .lost     (ev_msg_lost),
    .w1c_en   (gstat_we),
    .w1c_bits (reg_wdata[GS_W-1:0]),
    .mask_we  (gmask_we),
    .mask_d   (reg_wdata[GS_W-1:0]),
    .gstat    (gstat),
    .gmask    (gmask),
    .irq      (err_irq)
  );

  // sticky error cause, set wins over clear
  assign cause_set = hold ? 3'b000 : {ev_form_err, ev_bit_err, ev_stuff_err};
  assign cause_clr = cause_we ? {reg_wdata[EC_FORM], reg_wdata[EC_BIT], reg_wdata[EC_STUFF]} : 3'b000;

  always_ff @(posedge clk) begin
    if (rst || srst) cause <= '0;
    else             cause <= (cause & ~cause_clr) | cause_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      case (reg_addr)
        A_CTRL: begin
          reg_rdata[CT_CFG]   <= cfg_req;
          reg_rdata[CT_SLEEP] <= slp_req;
        end
        A_MODE:  reg_rdata[MD_CFGACK] <= cfg_ack;
        A_CNT:   reg_rdata[2*CNT_W-1:0] <= {tec, rec};
        A_GSTAT: reg_rdata[GS_W-1:0] <= gstat;
        A_GMASK: reg_rdata[GS_W-1:0] <= gmask;
        A_CAUSE: begin
          reg_rdata[EC_FORM]  <= cause[2];
          reg_rdata[EC_BIT]   <= cause[1];
          reg_rdata[EC_STUFF] <= cause[0];
        end
        A_SLEEP: reg_rdata[SL_ACK] <= slp_ack;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/can_fault_chk.sv
module can_fault_chk
  import can_fault_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int GS_W  = 11,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             srst,
  input logic             hold,
  input logic             bus_off,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic [GS_W-1:0]  gstat,
  input logic [GS_W-1:0]  gmask,
  input logic             err_irq,
  input logic             cfg_req,
  input logic             slp_ack,
  input logic             ev_msg_lost,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [DW-1:0]    reg_wdata
);
  AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (rst)
    !srst |=> err_irq == $past(|(gstat & gmask))); // R6

  AST_BUSOFF_ZEROES: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_off) |-> (tec == '0 && rec == '0)); // R3

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (hold && !srst) |=> ($stable(tec) && $stable(rec))); // R8

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    srst |=> (gstat == '0 && tec == '0 && rec == '0 && cfg_req && !bus_off)); // R10

  AST_LOST_SETS: assert property (@(posedge clk) disable iff (rst)
    (ev_msg_lost && !srst) |=> gstat[GS_LOST]); // R5

  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_SLEEP && reg_wdata == '0) |=> !slp_ack); // R9
endmodule

bind can_fault_supervisor can_fault_chk #(.CNT_W(CNT_W), .GS_W(GS_W), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .srst        (srst),
  .hold        (hold),
  .bus_off     (bus_off),
  .tec         (tec),
  .rec         (rec),
  .gstat       (gstat),
  .gmask       (gmask),
  .err_irq     (err_irq),
  .cfg_req     (cfg_req),
  .slp_ack     (slp_ack),
  .ev_msg_lost (ev_msg_lost),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata)
);

// File: tb/can_fault_supervisor_tb.sv
module can_fault_supervisor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_bit_err = 0, ev_form_err = 0, ev_stuff_err = 0, ev_while_tx = 0;
  logic        ev_tx_ok = 0, ev_rx_ok = 0, ev_msg_lost = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        err_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  can_fault_supervisor u_dut (
    .clk(clk), .rst(rst),
    .ev_bit_err(ev_bit_err), .ev_form_err(ev_form_err), .ev_stuff_err(ev_stuff_err),
    .ev_while_tx(ev_while_tx), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
    .ev_msg_lost(ev_msg_lost), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_irq(err_irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_tec, m_rec, m_bo, m_prev, m_gstat, m_gmask, m_irq, m_cause;
  int m_cfg_req, m_cfg_ack, m_slp_req, m_slp_ack, m_rd;
  int n_tec, n_rec, n_bo, n_gstat, n_cause, c, hold, errp, sr;

  function automatic int model_read(input int a);
    case (a)
      0: return (m_cfg_req << 7) | (m_slp_req << 5);
      1: return m_cfg_ack << 7;
      2: return (m_tec << 8) | m_rec;
      3: return m_gstat;
      4: return m_gmask;
      5: return m_cause;
      6: return m_slp_ack << 3;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_tec = 0; m_rec = 0; m_bo = 0; m_prev = 0; m_gstat = 0; m_gmask = 0;
      m_irq = 0; m_cause = 0; m_cfg_req = 1; m_cfg_ack = 1; m_slp_req = 0;
      m_slp_ack = 0; m_rd = 0;
    end else begin
      if (reg_rd) m_rd = model_read(int'(reg_addr));
      sr   = (reg_wr && reg_addr == 0 && reg_wdata[0]) ? 1 : 0;
      hold = (m_cfg_ack || m_slp_ack || m_bo) ? 1 : 0;
      errp = (ev_bit_err || ev_form_err || ev_stuff_err) ? 1 : 0;
      c = ((m_tec >= 96) ? 1 : 0) | ((m_rec >= 96) ? 2 : 0) |
          ((m_tec >= 128 || m_rec >= 128) ? 4 : 0) | (m_bo ? 8 : 0);
      n_tec = m_tec; n_rec = m_rec; n_bo = m_bo;
      if (!hold) begin
        if (errp) begin
          if (ev_while_tx) begin
            if (m_tec + 8 > 255) begin n_bo = 1; n_tec = 0; n_rec = 0; end
            else n_tec = m_tec + 8;
          end else n_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
        end else begin
          if (ev_tx_ok && m_tec > 0) n_tec = m_tec - 1;
          if (ev_rx_ok && m_rec > 0) n_rec = m_rec - 1;
        end
      end
      n_gstat = m_gstat;
      if (reg_wr && reg_addr == 3) n_gstat = n_gstat & ~(int'(reg_wdata) & 'h7FF);
      n_gstat = n_gstat | (c & ~m_prev) | (ev_msg_lost ? 'h80 : 0);
      n_cause = m_cause;
      if (reg_wr && reg_addr == 5) n_cause = n_cause & ~(int'(reg_wdata) & 'hC8);
      if (!hold) n_cause = n_cause | (ev_bit_err ? 'h40 : 0) | (ev_form_err ? 'h80 : 0) |
                           (ev_stuff_err ? 'h08 : 0);
      m_irq  = ((m_gstat & m_gmask) != 0) ? 1 : 0;
      m_prev = c;
      if (reg_wr && reg_addr == 4) m_gmask = int'(reg_wdata) & 'h7FF;
      m_cfg_ack = m_cfg_req;
      if (sr) begin
        m_tec = 0; m_rec = 0; m_bo = 0; m_prev = 0; m_gstat = 0; m_cause = 0; m_irq = 0;
        m_cfg_req = 1; m_slp_req = 0; m_slp_ack = 0;
      end else begin
        m_tec = n_tec; m_rec = n_rec; m_bo = n_bo; m_gstat = n_gstat; m_cause = n_cause;
        if (reg_wr && reg_addr == 0) begin
          m_cfg_req = reg_wdata[7]; m_slp_req = reg_wdata[5];
        end
        if (reg_wr && reg_addr == 6 && reg_wdata == 0) begin
          m_slp_req = 0; m_slp_ack = 0;
        end else m_slp_ack = m_slp_req;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (int'(err_irq) != m_irq) begin
        bad++;
        $display("FAIL model R6: err_irq=%0d expected=%0d", err_irq, m_irq);
      end
      total++;
      if (int'(reg_rdata) != m_rd) begin
        bad++;
        $display("FAIL model R1: reg_rdata=%04h expected=%04h", reg_rdata, m_rd[15:0]);
      end
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  // kind bits: 1 bit err, 2 form err, 4 stuff err, 8 while tx, 16 tx ok, 32 rx ok, 64 lost
  task automatic evt(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      ev_bit_err   = kind[0]; ev_form_err = kind[1]; ev_stuff_err = kind[2];
      ev_while_tx  = kind[3]; ev_tx_ok    = kind[4]; ev_rx_ok     = kind[5];
      ev_msg_lost  = kind[6];
      @(negedge clk);
    end
    {ev_bit_err, ev_form_err, ev_stuff_err, ev_while_tx, ev_tx_ok, ev_rx_ok, ev_msg_lost} = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit settle);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
    if (settle) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s: addr %0d read=%04h expected=%04h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    total++;
    if (err_irq !== exp) begin
      bad++;
      $display("FAIL %s: err_irq=%0d expected=%0d", tag, err_irq, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    irq_chk(1'b0, "R12");
    rd_chk(0, 16'h0080, "R12");
    rd_chk(1, 16'h0080, "R12");
    rd_chk(2, 16'h0000, "R12");
    // R8 leave configuration mode
    wr(0, 16'h0000, 1);
    rd_chk(1, 16'h0000, "R8");
    wr(4, 16'h008F, 1);
    // R1/R2/R7 receive errors up to warning
    evt(4, 96);
    repeat (2) @(negedge clk);
    rd_chk(2, 16'h0060, "R1");
    rd_chk(3, 16'h0002, "R2");
    irq_chk(1'b1, "R6");
    rd_chk(5, 16'h0008, "R7");
    // R4 clear all
    wr(3, 16'h07FF, 0);
    rd_chk(3, 16'h0000, "R4");
    irq_chk(1'b0, "R6");
    // R4 collision: clear and fresh rising edge in the same cycle
    evt(32, 1);
    @(negedge clk);
    evt(4, 1);
    wr(3, 16'h0002, 1);
    rd_chk(3, 16'h0002, "R4");
    // R11 error and success together
    wr(3, 16'h07FF, 1);
    evt(4 | 32, 1);
    rd_chk(2, 16'h0061, "R11");
    // R2 passive, R1 saturation
    evt(4, 31);
    @(negedge clk);
    rd_chk(3, 16'h0004, "R2");
    evt(4, 200);
    rd_chk(2, 16'h00FF, "R1");
    // R10 soft reset
    wr(0, 16'h0001, 1);
    rd_chk(2, 16'h0000, "R10");
    rd_chk(3, 16'h0000, "R10");
    rd_chk(1, 16'h0080, "R10");
    rd_chk(0, 16'h0080, "R10");
    // R8 events ignored in configuration mode
    evt(4, 3);
    rd_chk(2, 16'h0000, "R8");
    rd_chk(5, 16'h0000, "R8");
    wr(0, 16'h0000, 1);
    // R1/R2 transmit errors
    evt(1 | 8, 12);
    @(negedge clk);
    rd_chk(2, 16'h6000, "R1");
    rd_chk(3, 16'h0001, "R2");
    evt(16, 1);
    rd_chk(2, 16'h5F00, "R1");
    // R7 sticky cause and clear
    evt(2, 1);
    rd_chk(5, 16'h00C0, "R7");
    wr(5, 16'h0040, 0);
    rd_chk(5, 16'h0080, "R7");
    // R5 lost message
    evt(64, 1);
    rd_chk(3, 16'h0081, "R5");
    // R3 bus-off
    evt(1 | 8, 21);
    @(negedge clk);
    rd_chk(2, 16'h0000, "R3");
    rd_chk(3, 16'h008D, "R3");
    evt(4, 2);
    rd_chk(2, 16'h0000, "R3");
    // R9 sleep handshake
    wr(0, 16'h0001, 1);
    wr(0, 16'h0000, 1);
    wr(0, 16'h0020, 1);
    rd_chk(6, 16'h0008, "R9");
    evt(4, 1);
    rd_chk(2, 16'h0000, "R9");
    wr(6, 16'h0000, 1);
    rd_chk(6, 16'h0000, "R9");
    rd_chk(0, 16'h0000, "R9");
    evt(4, 1);
    rd_chk(2, 16'h0001, "R9");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog R12: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule